// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block serialises bytes onto a single asynchronous line, using a frame format held in an 8-bit line-control register. A byte comes in over a valid/ready handshake. The block then sends a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and a stop period of programmable length. Bit timing comes from a baud-tick strobe at sixteen times the bit rate. The block advances only on cycles where that strobe is high.

The control register chooses the word length, the stop period, the parity mode and a line-break override. Its top bit is a divisor-latch enable that is only stored and read back here. The transmitter copies the format fields when a frame begins, so software may rewrite the register at any time without corrupting the frame in flight. Setting the break bit pulls the line low at once and blocks new bytes. A frame already running keeps counting under the mask, so its timing is unchanged.

Top module: `sertx_lcr`

## Requirements
- R1: After reset the control register reads 0x00, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A frame is a start bit at 0 followed by the data bits, least significant first. Each bit lasts 16 baud ticks, and no state changes on a cycle with no tick.
- R3: Control bits [1:0] set the word length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits.
- R4: With control bit [2] at 0 the stop period is one bit (16 ticks) at 1. With bit [2] at 1 it is 24 ticks for 5-bit words and 32 ticks for 6 to 8-bit words.
- R5: Control bit [3] at 0 sends no parity bit. When bit [3] is 1, bits [5:4] select the parity bit: 00 gives odd parity, 01 gives even parity, 10 sends a constant 1, and 11 sends a constant 0. The parity bit follows the last data bit.
- R6: Input bits above the configured word length are neither sent nor counted in parity.
- R7: While control bit [6] is 1, `txd` is 0, `in_ready` is 0 and no byte is accepted. Clearing the bit returns the idle line to 1.
- R8: A break raised mid-frame forces `txd` to 0 for the rest of the frame. The frame still ends (`busy` falls) at its normal tick count.
- R9: The format is sampled when a byte is accepted. A register write during a frame changes only later frames.
- R10: `busy` is 1 from the start bit through the last stop tick. `in_ready` is 1 exactly when the transmitter is not busy and break is off.
- R11: Control bit [7] is stored and reads back on `ctl_q`, and it has no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Baud strobe at 16x bit rate |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register contents |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be accepted |
| txd | output | 1 | Serial line output |
| busy | output | 1 | Frame in progress |

## Verification
Several rules are checked by assertions on every cycle. The tick counter never reaches the current bit length, and nothing moves on a cycle without a tick. The idle line is high when break is off, and the stop period drives 1 unless break is on. A frame never starts during break, and the latched format stays fixed while the frame is running. Some behaviour depends on the whole serial waveform, and only the bench's scenarios show it. This covers the order of the data bits and which value each parity mode produces. It also covers the measured stop lengths, the masked tail of a frame hit by a mid-frame break, and the deferred effect of a register write made during a frame.

// File: rtl/sertx_lcr.sv
module sertx_lcr #(
  parameter int TPB = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_q,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       txd,
  output logic       busy
);
  localparam int CW = $clog2(2*TPB + 1);
  localparam logic [CW-1:0] T_ONE  = CW'(TPB);
  localparam logic [CW-1:0] T_HALF = CW'(TPB + TPB/2);
  localparam logic [CW-1:0] T_TWO  = CW'(2*TPB);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [7:0]    ctl_r;
  logic [CW-1:0] sub, stop_len, dur;
  logic [2:0]    idx, last_idx;
  logic [7:0]    shreg;
  logic          par_on, par_bit, last, accept, raw;
  logic [7:0]    mask;
  logic          xr, pcalc;

  assign ctl_q    = ctl_r;
  assign busy     = (st != S_IDLE);
  assign in_ready = !busy && !ctl_r[6];
  assign accept   = in_valid && in_ready;
  assign dur      = (st == S_STOP) ? stop_len : T_ONE;
  assign last     = tick && (sub == dur - 1'b1);

  assign mask  = 8'hFF >> (2'd3 - ctl_r[1:0]);
  assign xr    = ^(in_data & mask);
  assign pcalc = ctl_r[5] ? ~ctl_r[4] : (ctl_r[4] ? xr : ~xr);

  always_comb begin
    case (st)
      S_START: raw = 1'b0;
      S_DATA:  raw = shreg[idx];
      S_PAR:   raw = par_bit;
      default: raw = 1'b1;
    endcase
  end
  assign txd = raw && !ctl_r[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_r <= '0;
    else if (ctl_we) ctl_r <= ctl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sub      <= '0;
      idx      <= '0;
      shreg    <= '0;
      last_idx <= '0;
      par_on   <= 1'b0;
      par_bit  <= 1'b0;
      stop_len <= T_ONE;
    end else if (st == S_IDLE) begin
      if (accept) begin
        st       <= S_START;
        sub      <= '0;
        idx      <= '0;
        shreg    <= in_data;
        last_idx <= {1'b1, ctl_r[1:0]};
        par_on   <= ctl_r[3];
        par_bit  <= pcalc;
        stop_len <= !ctl_r[2] ? T_ONE : (ctl_r[1:0] == 2'd0 ? T_HALF : T_TWO);
      end
    end else if (tick) begin
      if (!last) sub <= sub + 1'b1;
      else begin
        sub <= '0;
        case (st)
          S_START: st <= S_DATA;
          S_DATA:
            if (idx == last_idx) st <= par_on ? S_PAR : S_STOP;
            else idx <= idx + 1'b1;
          S_PAR:   st <= S_STOP;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_sub_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sub < dur));
  p_notick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(sub) && $stable(st) && $stable(idx)));
  p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && !ctl_r[6]) |-> txd);
  p_no_start_brk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_r[6]) |=> !busy);
  p_hold_fmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(stop_len) && $stable(par_on) && $stable(last_idx)));
  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctl_r[6]) |-> (txd && in_ready));
endmodule

// File: tb/sertx_lcr_test.sv
module sertx_lcr_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, tick = 0, ctl_we = 0, in_valid = 0;
  logic [7:0] ctl_wdata = 0, in_data = 0, ctl_q;
  logic in_ready, txd, busy;
  int total = 0, bad = 0, tp = 1, tcnt = 0, cyc = 0;
  logic [511:0] wave;
  int wlen;

  sertx_lcr uut (.clk(clk), .rst_n(rst_n), .tick(tick), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd), .busy(busy));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    tick <= (tcnt == 0);
    tcnt <= (tcnt + 1 >= tp) ? 0 : tcnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic expect_bits(input logic [7:0] d, input logic [7:0] c,
                             output logic [15:0] bits, output int nb, output int ticks);
    int wl; logic p; logic x;
    wl = 5 + int'(c[1:0]);
    bits = '0; nb = 0; x = 0;
    bits[nb++] = 1'b0;
    for (int i = 0; i < wl; i++) begin bits[nb++] = d[i]; x ^= d[i]; end
    if (c[3]) begin
      case (c[5:4])
        2'b00: p = ~x;
        2'b01: p = x;
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      bits[nb++] = p;
    end
    ticks = 16 * nb + (!c[2] ? 16 : (wl == 5 ? 24 : 32));
  endtask

  task automatic run_frame(input logic [7:0] d, input int poke_at, input logic [7:0] poke_v);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
    wlen = 0; wave = '0;
    while (busy && wlen < 500) begin
      wave[wlen] = txd;
      if (wlen == poke_at) begin ctl_we = 1; ctl_wdata = poke_v; end
      else ctl_we = 0;
      wlen++;
      @(negedge clk);
    end
    ctl_we = 0;
  endtask

  task automatic frame_test(input string req, input logic [7:0] d, input logic [7:0] c);
    logic [15:0] eb, ab; int nb, tk, diff;
    expect_bits(d, c, eb, nb, tk);
    run_frame(d, -1, 8'h00);
    ab = '0;
    for (int k = 0; k < nb; k++) ab[k] = wave[tp*(16*k+8)];
    chk({req, " bits"}, 32'(ab), 32'(eb));
    diff = wlen - tp*tk;
    if (tp == 1) chk({req, " length"}, wlen, tk);
    else chk({req, " length"}, (diff <= 1 && diff >= -1) ? tk : wlen, tk);
  endtask

  task automatic t_reset;
    chk("R1 ctl", ctl_q, 8'h00);
    chk("R1 txd/busy/ready", {txd, busy, in_ready}, 3'b101);
  endtask

  task automatic t_formats;
    wr_ctl(8'h03); frame_test("R2 R3 8N1", 8'hA5, 8'h03);
    wr_ctl(8'h04); frame_test("R4 5-bit 1.5 stop", 8'h16, 8'h04);
    wr_ctl(8'h1E); frame_test("R5 7 even 2 stop", 8'h53, 8'h1E);
    wr_ctl(8'h09); frame_test("R5 6 odd", 8'h2A, 8'h09);
    wr_ctl(8'h2B); frame_test("R5 stick1", 8'h00, 8'h2B);
    wr_ctl(8'h3B); frame_test("R5 stick0", 8'hFF, 8'h3B);
    wr_ctl(8'h08); frame_test("R6 upper bits ignored", 8'hE1, 8'h08);
    wr_ctl(8'h8F); chk("R11 readback", ctl_q, 8'h8F);
    frame_test("R11 latch bit no effect", 8'h3C, 8'h8F);
  endtask

  task automatic t_ticks;
    tp = 2; wr_ctl(8'h03);
    frame_test("R2 sparse ticks", 8'h69, 8'h03);
    tp = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_break;
    int seen;
    wr_ctl(8'h43);
    chk("R7 break line", {txd, in_ready}, 2'b00);
    in_valid = 1; in_data = 8'h55; seen = 0;
    repeat (40) begin @(negedge clk); if (busy) seen++; end
    in_valid = 0;
    chk("R7 no accept", seen, 0);
    wr_ctl(8'h03);
    chk("R7 release", {txd, busy, in_ready}, 3'b101);
  endtask

  task automatic t_break_mid;
    int zeros;
    run_frame(8'hFF, 40, 8'h43);
    zeros = 0;
    for (int i = 42; i < wlen; i++) if (wave[i]) zeros++;
    chk("R8 masked tail", zeros, 0);
    chk("R8 length", wlen, 160);
    wr_ctl(8'h03);
  endtask

  task automatic t_defer;
    logic [15:0] ab, eb; int nb, tk;
    run_frame(8'hC3, 30, 8'h00);
    expect_bits(8'hC3, 8'h03, eb, nb, tk);
    ab = '0;
    for (int k = 0; k < nb; k++) ab[k] = wave[16*k+8];
    chk("R9 old format bits", 32'(ab), 32'(eb));
    chk("R9 old format length", wlen, tk);
    frame_test("R9 new format next", 8'hC3, 8'h00);
    chk("R10 idle after", {busy, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_formats;
    t_ticks;
    t_break;
    t_break_mid;
    t_defer;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule